// File: doc/BRIEF.md
# Saturating Up/Down Event Counter

This block keeps a signed tally of events arriving on two single-bit inputs. One input adds to the tally and the other subtracts from it. Only a change from low to high counts as an event. A signal held high counts once, however long it stays high. Each event moves the tally by exactly one. The tally stops at the largest and smallest values its width can hold and never wraps.

Two control inputs override counting. The clear input forces the tally to zero. The load input copies a preset word into the tally. Two registered flags compare the tally with fixed limits. The upper flag shows that the tally has reached or passed the preset. The lower flag shows that the tally is zero or negative. A controller uses the upper flag as a target-reached signal and the lower flag as an exhausted signal.

Top module: `evt_updown_counter`

## Requirements
- R1: Only a rising edge counts, meaning a cycle where the input is 1 and was 0 in the previous cycle. An increment input held high for several cycles adds exactly one.
- R2: The clear input, sampled high at a clock edge, sets the count to zero at that edge. A rising edge on either event input in that cycle is discarded and is not counted later.
- R3: The load input, sampled high with clear low, sets the count to the preset word at that edge. The preset word is two's-complement.
- R4: Priority is clear, then load, then counting. With clear and load both high the count becomes zero. With load high, the preset is taken and any event edge in that cycle is ignored.
- R5: When rising edges arrive on both event inputs in the same cycle, with clear and load low, the count does not change.
- R6: `at_target` is 1 exactly when the count, read as signed, is greater than or equal to the signed preset. It is registered, updates at the same edge as the count, and uses the preset sampled at that edge.
- R7: `at_floor` is 1 exactly when the signed count is less than or equal to zero. It updates at the same edge as the count.
- R8: At the signed maximum (0 followed by all ones), an increment edge leaves the count unchanged. At the signed minimum (1 followed by all zeros), a decrement edge leaves it unchanged.
- R9: A synchronous active-high `rst` sets the count to zero, sets `at_floor` to 1, sets `at_target` to (0 >= preset), and clears the stored previous levels of both event inputs to 0.
- R10: Outside clear and load, the count changes by at most one per cycle. Each accepted increment edge adds one and each accepted decrement edge subtracts one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inc_evt | input | 1 | Event input; a rising edge adds one |
| dec_evt | input | 1 | Event input; a rising edge subtracts one |
| clear | input | 1 | Forces the count to zero |
| load | input | 1 | Copies the preset into the count |
| preset | input | CNT_W | Signed preset word |
| count | output | CNT_W | Signed count, registered |
| at_target | output | 1 | Count >= preset, registered |
| at_floor | output | 1 | Count <= 0, registered |

## Verification
A wrong stored edge history shows up one cycle after a level is held or released. It appears as an extra or missing step on `count`. A bad saturation guard shows at the first event past either limit, as a jump to the opposite extreme. A flag computed from a stale count or the wrong signedness disagrees with the count in the very cycle the count crosses zero or the preset. A small width makes every preset, every crossing and both limits reachable in a short sweep.

// File: rtl/ucnt_pkg.sv
package ucnt_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_CLR  = 3'd1,
    OP_LOAD = 3'd2,
    OP_INC  = 3'd3,
    OP_DEC  = 3'd4
  } cnt_op_e;
endpackage

// File: rtl/ucnt_edge.sv
module ucnt_edge #(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] lvl_i,
  output logic [LANES-1:0] rise_o
);
  // Each lane keeps the level it saw on the previous cycle.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic prev_q;
    always_ff @(posedge clk) begin
      if (rst) prev_q <= 1'b0;
      else     prev_q <= lvl_i[g];
    end
    assign rise_o[g] = lvl_i[g] & ~prev_q;
  end
endmodule

// File: rtl/ucnt_arb.sv
module ucnt_arb
  import ucnt_pkg::*;
(
  input  logic    clear_i,
  input  logic    load_i,
  input  logic    up_i,
  input  logic    dn_i,
  output cnt_op_e op_o
);
  always_comb begin
    if (clear_i)            op_o = OP_CLR;
    else if (load_i)        op_o = OP_LOAD;
    else if (up_i && !dn_i) op_o = OP_INC;
    else if (dn_i && !up_i) op_o = OP_DEC;
    else                    op_o = OP_HOLD;
  end
endmodule

// File: rtl/ucnt_core.sv
module ucnt_core
  import ucnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cnt_op_e          op_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] count_o,
  output logic             target_o,
  output logic             floor_o
);
  localparam logic [CNT_W-1:0] MAX_V = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] MIN_V = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             tgt_q, flr_q;

  always_comb begin
    unique case (op_i)
      OP_CLR:  cnt_nxt = '0;
      OP_LOAD: cnt_nxt = preset_i;
      OP_INC:  cnt_nxt = (cnt_q == MAX_V) ? cnt_q : cnt_q + 1'b1;
      OP_DEC:  cnt_nxt = (cnt_q == MIN_V) ? cnt_q : cnt_q - 1'b1;
      default: cnt_nxt = cnt_q;
    endcase
  end

  // Flags are taken from the value the count register is about to hold.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tgt_q <= ($signed(preset_i) <= $signed({CNT_W{1'b0}}));
      flr_q <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      tgt_q <= ($signed(cnt_nxt) >= $signed(preset_i));
      flr_q <= cnt_nxt[CNT_W-1] | (cnt_nxt == '0);
    end
  end

  assign count_o  = cnt_q;
  assign target_o = tgt_q;
  assign floor_o  = flr_q;
endmodule

// File: rtl/evt_updown_counter.sv
module evt_updown_counter
  import ucnt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc_evt,
  input  logic             dec_evt,
  input  logic             clear,
  input  logic             load,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] count,
  output logic             at_target,
  output logic             at_floor
);
  localparam int LANES = 2;

  logic [LANES-1:0] rise;
  cnt_op_e          op;

  ucnt_edge #(.LANES(LANES)) u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  ({dec_evt, inc_evt}),
    .rise_o (rise)
  );

  ucnt_arb u_arb (
    .clear_i (clear),
    .load_i  (load),
    .up_i    (rise[0]),
    .dn_i    (rise[1]),
    .op_o    (op)
  );

  ucnt_core #(.CNT_W(CNT_W)) u_core (
    .clk      (clk),
    .rst      (rst),
    .op_i     (op),
    .preset_i (preset),
    .count_o  (count),
    .target_o (at_target),
    .floor_o  (at_floor)
  );
endmodule

// File: rtl/ucnt_chk.sv
module ucnt_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             inc_evt,
  input logic             dec_evt,
  input logic             clear,
  input logic             load,
  input logic [CNT_W-1:0] preset,
  input logic [CNT_W-1:0] count,
  input logic             at_target,
  input logic             at_floor
);
  localparam logic [CNT_W-1:0] MAX_V = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] MIN_V = {1'b1, {(CNT_W-1){1'b0}}};

  // Set once a full cycle outside reset has gone by, so $past sees live inputs.
  logic seen_q;
  always_ff @(posedge clk) begin
    if (rst) seen_q <= 1'b0;
    else     seen_q <= 1'b1;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear |=> count == '0); // R2

  AST_LOAD_PRESET: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> count == $past(preset)); // R3

  AST_BOTH_EDGES_HOLD: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $rose(inc_evt) && $rose(dec_evt) && !clear && !load) |=> $stable(count)); // R5

  AST_LEVEL_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (seen_q && $stable(inc_evt) && $stable(dec_evt) && !clear && !load) |=> $stable(count)); // R1

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (!clear && !load) |=> (count == $past(count) || count == $past(count) + 1'b1
                           || count == $past(count) - 1'b1)); // R10

  AST_NO_WRAP_HI: assert property (@(posedge clk) disable iff (rst)
    (count == MAX_V && !clear && !load) |=> count != MIN_V); // R8

  AST_NO_WRAP_LO: assert property (@(posedge clk) disable iff (rst)
    (count == MIN_V && !clear && !load) |=> count != MAX_V); // R8

  AST_FLOOR_FLAG: assert property (@(posedge clk) disable iff (rst)
    at_floor == ($signed(count) <= $signed({CNT_W{1'b0}}))); // R7

  AST_TARGET_FLAG: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> at_target == ($signed(count) >= $signed($past(preset)))); // R6
endmodule

bind evt_updown_counter ucnt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .inc_evt   (inc_evt),
  .dec_evt   (dec_evt),
  .clear     (clear),
  .load      (load),
  .preset    (preset),
  .count     (count),
  .at_target (at_target),
  .at_floor  (at_floor)
);

// File: tb/tb_evt_updown_counter.sv
module tb_evt_updown_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W    = 4;
  localparam int MAXI = (1 << (W-1)) - 1;
  localparam int MINI = -(1 << (W-1));

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inc_evt = 1'b0, dec_evt = 1'b0, clear = 1'b0, load = 1'b0;
  logic [W-1:0] preset = '0;
  logic [W-1:0] count;
  logic         at_target, at_floor;

  int n_chk = 0, n_fail = 0;
  int m = 0;   // model count
  int mp = 0;  // model preset
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_updown_counter #(.CNT_W(W)) dut (
    .clk(clk), .rst(rst), .inc_evt(inc_evt), .dec_evt(dec_evt),
    .clear(clear), .load(load), .preset(preset),
    .count(count), .at_target(at_target), .at_floor(at_floor)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    chk({tag, " count"}, int'($signed(count)), m);
    chk({tag, " R6 at_target"}, int'(at_target), int'(m >= mp));
    chk({tag, " R7 at_floor"}, int'(at_floor), int'(m <= 0));
  endtask

  function automatic int sat(input int v);
    if (v > MAXI) return MAXI;
    if (v < MINI) return MINI;
    return v;
  endfunction

  // One-cycle stimulus from all-low inputs, checked after the edge, then released.
  task automatic pulse(input bit u, input bit d, input bit c, input bit l, input string tag);
    inc_evt = u; dec_evt = d; clear = c; load = l;
    @(negedge clk);
    if (c)           m = 0;
    else if (l)      m = mp;
    else if (u && !d) m = sat(m + 1);
    else if (d && !u) m = sat(m - 1);
    chk_all(tag);
    inc_evt = 0; dec_evt = 0; clear = 0; load = 0;
    @(negedge clk);
    chk_all({tag, " idle"});
  endtask

  task automatic set_preset(input int p);
    preset = W'(p); mp = p;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    preset = W'(3); mp = 3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset state
    chk("R9 reset count", int'($signed(count)), 0);
    chk("R9 reset at_floor", int'(at_floor), 1);
    chk("R9 reset at_target", int'(at_target), 0);

    // R10 R8 R6 R7: sweep every preset through both saturation limits
    for (int p = MINI; p <= MAXI; p++) begin
      set_preset(p);
      pulse(0, 0, 1, 0, "R2 clear");
      for (int k = 0; k < MAXI + 2; k++) pulse(1, 0, 0, 0, "R10 R8 up");
      for (int k = 0; k < MAXI - MINI + 2; k++) pulse(0, 1, 0, 0, "R10 R8 down");
    end

    // R3: load every preset value
    for (int p = MINI; p <= MAXI; p++) begin
      set_preset(p);
      pulse(0, 0, 0, 1, "R3 load");
    end

    // R4: priority
    set_preset(5);
    pulse(1, 0, 0, 0, "R4 setup");
    pulse(1, 0, 1, 1, "R4 clear over load");
    pulse(0, 1, 0, 1, "R4 load over edge");
    pulse(1, 0, 0, 1, "R4 load over up edge");

    // R5: simultaneous edges
    pulse(1, 1, 0, 0, "R5 both edges");
    set_preset(-2);
    pulse(0, 0, 0, 1, "R5 load neg");
    pulse(1, 1, 0, 0, "R5 both edges neg");

    // R1: level held counts once
    pulse(0, 0, 1, 0, "R1 clear");
    inc_evt = 1;
    @(negedge clk); m = m + 1; chk_all("R1 first edge");
    @(negedge clk); chk_all("R1 held");
    @(negedge clk); chk_all("R1 held again");
    dec_evt = 1;
    @(negedge clk); m = m - 1; chk_all("R1 dec edge while inc held");
    inc_evt = 0; dec_evt = 0;
    @(negedge clk); chk_all("R1 release");

    // R2: edge during clear is discarded, not counted later
    pulse(1, 0, 0, 0, "R2 pre");
    inc_evt = 1; clear = 1;
    @(negedge clk); m = 0; chk_all("R2 clear with edge");
    clear = 0;
    @(negedge clk); chk_all("R2 edge discarded");
    inc_evt = 0;
    @(negedge clk); chk_all("R2 release");

    // R9: reset mid-run with input high clears edge history
    pulse(1, 0, 0, 0, "R9 pre");
    set_preset(0);
    inc_evt = 1; rst = 1;
    @(negedge clk); m = 0;
    chk("R9 rst count", int'($signed(count)), 0);
    chk("R9 rst at_target", int'(at_target), 1);
    chk("R9 rst at_floor", int'(at_floor), 1);
    rst = 0;
    @(negedge clk); m = 1; chk_all("R9 edge after rst");
    inc_evt = 0;
    @(negedge clk); chk_all("R9 release");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule